// File: doc/BRIEF.md
# Serial NOR Program/Erase Engine

This block holds a small on-chip byte array that stands in for the storage of a serial NOR flash. A command front end issues single-byte program requests and erase requests. It also supplies the current write-enable state. The block applies these requests to the array and reports their progress. A separate combinational read port returns any byte of the array for the front end's read commands.

A program request completes in one clock. By default it can only clear bits, because the stored byte becomes the AND of the old byte and the new data. An overwrite-mode parameter turns the array into an EEPROM-like store in which the new byte replaces the old one. An erase fills an aligned region with 0xFF. It advances one byte per clock and holds busy high until the region is done, then gives a one-cycle done pulse. There are four erase kinds: small block, medium block, sector and whole array. The small and medium kinds each have a capability parameter. If the capability is absent, an error pulse is raised but the erase still runs.

Array size is the sector size times the sector count. The small and medium erase sizes are parameters, so that scaled-down arrays remain usable.

Top module: `nor_pe_engine`

## Requirements
- R1: After reset every byte of the array reads 0xFF, and busy_o, done_o, reject_o, cap_err_o and prot_err_o are all low.
- R2: An accepted erase sets every byte of its region to 0xFF and leaves all bytes outside the region unchanged. The region length is chosen by erase_kind_i: 0 = SMALL_ERASE_BYTES, 1 = MID_ERASE_BYTES, 2 = SECTOR_BYTES, 3 = the whole array.
- R3: The erase region starts at erase_addr_i aligned down to a multiple of the region length. A whole-array erase starts at address 0.
- R4: An erase request is accepted when busy_o is low and wr_en_i is high. busy_o is then high from the next cycle for exactly as many cycles as the region has bytes. done_o is high for one cycle, the first cycle in which busy_o is low again.
- R5: An accepted erase of kind 0 with CAP_SMALL clear, or of kind 1 with CAP_MID clear, raises cap_err_o for one cycle, the cycle after acceptance, and the erase still runs. Kinds 2 and 3, and kinds whose capability is set, never raise cap_err_o.
- R6: An erase request made while idle with wr_en_i low is ignored: busy_o, done_o and cap_err_o stay low and the array is unchanged.
- R7: With OVERWRITE clear, an accepted program stores the old byte AND prog_data_i at prog_addr_i.
- R8: With OVERWRITE set, an accepted program stores prog_data_i unchanged at prog_addr_i.
- R9: A program request made while idle, with no erase request and wr_en_i low, raises prot_err_o for one cycle, the next cycle, and leaves the array unchanged.
- R10: While busy_o is high, any program or erase request is refused with a one-cycle reject_o pulse in the next cycle. It neither changes the array nor alters the running erase or its length.
- R11: When a program request and an erase request arrive together while idle, the erase is handled as if it were alone, the program is dropped, and reject_o pulses in the next cycle.
- R12: An accepted program never raises busy_o, and the new byte appears on rd_data_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write-enable state from the command front end |
| prog_req_i | input | 1 | Single-byte program request |
| prog_addr_i | input | AW | Program byte address |
| prog_data_i | input | 8 | Program data |
| erase_req_i | input | 1 | Erase request |
| erase_kind_i | input | 2 | 0 small, 1 medium, 2 sector, 3 whole array |
| erase_addr_i | input | AW | Any address inside the region to erase |
| rd_addr_i | input | AW | Read port address |
| rd_data_o | output | 8 | Array byte at rd_addr_i (combinational) |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle pulse when an erase finishes |
| reject_o | output | 1 | One-cycle pulse for a refused request |
| cap_err_o | output | 1 | One-cycle pulse for an unsupported erase size |
| prot_err_o | output | 1 | One-cycle pulse for a program with write-enable low |

## Verification
The main instance is built as a 256-byte array of four 64-byte sectors, with 16-byte small and 32-byte medium erases. The small capability is set and the medium capability is clear. With these values the bench can sweep and compare every byte after each erase. Each erase kind is exercised at an unaligned address and finishes in at most 256 cycles. Both the silent and the flagged outcomes of the capability check can be seen. A second instance, identical except that overwrite mode is set, receives the same program vectors, so the AND and replace behaviours are compared side by side.

// File: rtl/nor_pe_pkg.sv
package nor_pe_pkg;
  typedef enum logic [1:0] {
    KIND_SMALL  = 2'd0,
    KIND_MID    = 2'd1,
    KIND_SECTOR = 2'd2,
    KIND_CHIP   = 2'd3
  } erase_kind_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/nor_region_calc.sv
module nor_region_calc
  import nor_pe_pkg::*;
#(
  parameter int unsigned AW           = 11,
  parameter int unsigned LW           = 12,
  parameter int unsigned DEPTH        = 2048,
  parameter int unsigned SMALL_BYTES  = 128,
  parameter int unsigned MID_BYTES    = 256,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter bit          CAP_SMALL    = 1'b1,
  parameter bit          CAP_MID      = 1'b0
) (
  input  erase_kind_e    kind_i,
  input  logic [AW-1:0]  addr_i,
  output logic [AW-1:0]  base_o,
  output logic [LW-1:0]  len_o,
  output logic           cap_miss_o
);
  localparam logic [AW-1:0] SMALL_MASK  = ~AW'(SMALL_BYTES - 1);
  localparam logic [AW-1:0] MID_MASK    = ~AW'(MID_BYTES - 1);
  localparam logic [AW-1:0] SECTOR_MASK = ~AW'(SECTOR_BYTES - 1);

  always_comb begin
    base_o     = '0;
    len_o      = LW'(DEPTH);
    cap_miss_o = 1'b0;
    unique case (kind_i)
      KIND_SMALL: begin
        base_o     = addr_i & SMALL_MASK;
        len_o      = LW'(SMALL_BYTES);
        cap_miss_o = !CAP_SMALL;
      end
      KIND_MID: begin
        base_o     = addr_i & MID_MASK;
        len_o      = LW'(MID_BYTES);
        cap_miss_o = !CAP_MID;
      end
      KIND_SECTOR: begin
        base_o = addr_i & SECTOR_MASK;
        len_o  = LW'(SECTOR_BYTES);
      end
      default: begin
        base_o = '0;
        len_o  = LW'(DEPTH);
      end
    endcase
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
  parameter int unsigned AW = 11,
  parameter int unsigned LW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fill_we_o,
  output logic [AW-1:0] fill_addr_o
);
  logic          busy_q, done_q;
  logic [AW-1:0] cursor_q;
  logic [LW-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cursor_q <= '0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q   <= 1'b1;
        cursor_q <= base_i;
        remain_q <= len_i;
      end else if (busy_q) begin
        cursor_q <= cursor_q + AW'(1);
        remain_q <= remain_q - LW'(1);
        if (remain_q == LW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // one byte per clock while busy
  assign fill_we_o   = busy_q;
  assign fill_addr_o = cursor_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array
  import nor_pe_pkg::*;
#(
  parameter int unsigned DEPTH     = 2048,
  parameter int unsigned AW        = 11,
  parameter bit          OVERWRITE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_we_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic          prog_we_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem_q [DEPTH];
  logic [7:0] prog_byte;

  generate
    if (OVERWRITE) begin : g_replace
      assign prog_byte = prog_data_i;
    end else begin : g_clear_only
      assign prog_byte = prog_data_i & mem_q[prog_addr_i];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_BYTE;
    end else if (fill_we_i) begin
      mem_q[fill_addr_i] <= ERASED_BYTE;
    end else if (prog_we_i) begin
      mem_q[prog_addr_i] <= prog_byte;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/nor_pe_engine.sv
module nor_pe_engine
  import nor_pe_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES      = 512,
  parameter int unsigned SECTOR_COUNT      = 4,
  parameter int unsigned SMALL_ERASE_BYTES = 128,
  parameter int unsigned MID_ERASE_BYTES   = 256,
  parameter bit          CAP_SMALL         = 1'b1,
  parameter bit          CAP_MID           = 1'b0,
  parameter bit          OVERWRITE         = 1'b0,
  localparam int unsigned DEPTH = SECTOR_BYTES * SECTOR_COUNT,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          prog_req_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [7:0]    prog_data_i,
  input  logic          erase_req_i,
  input  logic [1:0]    erase_kind_i,
  input  logic [AW-1:0] erase_addr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          reject_o,
  output logic          cap_err_o,
  output logic          prot_err_o
);
  logic          busy;
  logic          erase_go, prog_go;
  logic [AW-1:0] region_base;
  logic [LW-1:0] region_len;
  logic          cap_miss;
  logic          fill_we;
  logic [AW-1:0] fill_addr;
  logic          reject_q, cap_q, prot_q;

  nor_region_calc #(
    .AW(AW), .LW(LW), .DEPTH(DEPTH),
    .SMALL_BYTES(SMALL_ERASE_BYTES), .MID_BYTES(MID_ERASE_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID)
  ) i_region (
    .kind_i     (erase_kind_e'(erase_kind_i)),
    .addr_i     (erase_addr_i),
    .base_o     (region_base),
    .len_o      (region_len),
    .cap_miss_o (cap_miss)
  );

  // erase wins over a same-cycle program; nothing starts while busy
  assign erase_go = erase_req_i && !busy && wr_en_i;
  assign prog_go  = prog_req_i && !busy && !erase_req_i && wr_en_i;

  nor_erase_seq #(.AW(AW), .LW(LW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (erase_go),
    .base_i      (region_base),
    .len_i       (region_len),
    .busy_o      (busy),
    .done_o      (done_o),
    .fill_we_o   (fill_we),
    .fill_addr_o (fill_addr)
  );

  nor_byte_array #(.DEPTH(DEPTH), .AW(AW), .OVERWRITE(OVERWRITE)) i_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_we_i   (fill_we),
    .fill_addr_i (fill_addr),
    .prog_we_i   (prog_go),
    .prog_addr_i (prog_addr_i),
    .prog_data_i (prog_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reject_q <= 1'b0;
      cap_q    <= 1'b0;
      prot_q   <= 1'b0;
    end else begin
      reject_q <= (busy && (prog_req_i || erase_req_i)) ||
                  (!busy && prog_req_i && erase_req_i);
      cap_q    <= erase_go && cap_miss;
      prot_q   <= prog_req_i && !busy && !erase_req_i && !wr_en_i;
    end
  end

  assign busy_o     = busy;
  assign reject_o   = reject_q;
  assign cap_err_o  = cap_q;
  assign prot_err_o = prot_q;
endmodule

// File: rtl/nor_pe_engine_chk.sv
module nor_pe_engine_chk #(
  parameter int unsigned AW        = 11,
  parameter bit          CAP_SMALL = 1'b1,
  parameter bit          CAP_MID   = 1'b0,
  parameter bit          OVERWRITE = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          prog_req_i,
  input logic [AW-1:0] prog_addr_i,
  input logic [7:0]    prog_data_i,
  input logic          erase_req_i,
  input logic [1:0]    erase_kind_i,
  input logic [AW-1:0] rd_addr_i,
  input logic [7:0]    rd_data_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          reject_o,
  input logic          cap_err_o,
  input logic          prot_err_o
);
  a_r4_busy_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_en_i && erase_req_i |=> busy_o);

  a_r4_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r5_small_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_en_i && erase_req_i && erase_kind_i == 2'd0 |=> cap_err_o == !CAP_SMALL);

  a_r5_mid_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_en_i && erase_req_i && erase_kind_i == 2'd1 |=> cap_err_o == !CAP_MID);

  a_r5_big_no_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_i && erase_kind_i[1] |=> !cap_err_o);

  a_r6_locked_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && erase_req_i && !wr_en_i |=> !busy_o && !cap_err_o);

  a_r9_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && prog_req_i && !erase_req_i && !wr_en_i |=> prot_err_o);

  a_r10_busy_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (prog_req_i || erase_req_i) |=> reject_o && busy_o || done_o);

  a_r11_clash_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && prog_req_i && erase_req_i |=> reject_o);

  a_r7_and_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !OVERWRITE && !busy_o && prog_req_i && !erase_req_i && wr_en_i && rd_addr_i == prog_addr_i
    |=> (rd_addr_i != $past(rd_addr_i)) || (rd_data_o == ($past(rd_data_o) & $past(prog_data_i))));

  a_r8_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    OVERWRITE && !busy_o && prog_req_i && !erase_req_i && wr_en_i && rd_addr_i == prog_addr_i
    |=> (rd_addr_i != $past(rd_addr_i)) || (rd_data_o == $past(prog_data_i)));

  a_r12_prog_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && prog_req_i && !erase_req_i |=> !busy_o);
endmodule

bind nor_pe_engine nor_pe_engine_chk #(
  .AW(AW), .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID), .OVERWRITE(OVERWRITE)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .prog_req_i   (prog_req_i),
  .prog_addr_i  (prog_addr_i),
  .prog_data_i  (prog_data_i),
  .erase_req_i  (erase_req_i),
  .erase_kind_i (erase_kind_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .reject_o     (reject_o),
  .cap_err_o    (cap_err_o),
  .prot_err_o   (prot_err_o)
);

// File: tb/test_nor_pe_engine.sv
`timescale 1ns/1ps
module test_nor_pe_engine;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, prog_req, erase_req;
  logic [7:0] prog_addr, prog_data, erase_addr, rd_addr;
  logic [1:0] erase_kind;
  logic [7:0] rd_data, rd_data_ow;
  logic       busy, done, reject, cap_err, prot_err;
  logic       busy_ow, done_ow, reject_ow, cap_ow, prot_ow;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  nor_pe_engine #(
    .SECTOR_BYTES(64), .SECTOR_COUNT(4), .SMALL_ERASE_BYTES(16), .MID_ERASE_BYTES(32),
    .CAP_SMALL(1'b1), .CAP_MID(1'b0), .OVERWRITE(1'b0)
  ) i_nor_pe_engine (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .prog_req_i(prog_req),
    .prog_addr_i(prog_addr), .prog_data_i(prog_data), .erase_req_i(erase_req),
    .erase_kind_i(erase_kind), .erase_addr_i(erase_addr), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .done_o(done), .reject_o(reject),
    .cap_err_o(cap_err), .prot_err_o(prot_err)
  );

  nor_pe_engine #(
    .SECTOR_BYTES(64), .SECTOR_COUNT(4), .SMALL_ERASE_BYTES(16), .MID_ERASE_BYTES(32),
    .CAP_SMALL(1'b1), .CAP_MID(1'b0), .OVERWRITE(1'b1)
  ) i_nor_pe_engine_ow (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .prog_req_i(prog_req),
    .prog_addr_i(prog_addr), .prog_data_i(prog_data), .erase_req_i(erase_req),
    .erase_kind_i(erase_kind), .erase_addr_i(erase_addr), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data_ow), .busy_o(busy_ow), .done_o(done_ow), .reject_o(reject_ow),
    .cap_err_o(cap_ow), .prot_err_o(prot_ow)
  );

  // {addr, data, wr_en, expected AND result, expected overwrite result, expected prot}
  localparam logic [33:0] VEC [8] = '{
    {8'h10, 8'hF0, 1'b1, 8'hF0, 8'hF0, 1'b0},
    {8'h10, 8'h3C, 1'b1, 8'h30, 8'h3C, 1'b0},
    {8'h10, 8'hFF, 1'b1, 8'h30, 8'hFF, 1'b0},
    {8'h11, 8'hA5, 1'b0, 8'hFF, 8'hFF, 1'b1},
    {8'h11, 8'h5A, 1'b1, 8'h5A, 8'h5A, 1'b0},
    {8'hFF, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h81, 1'b1, 8'h81, 8'h81, 1'b0},
    {8'h10, 8'h0F, 1'b1, 8'h00, 8'h0F, 1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sweep(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = 8'(i);
      #0.004;
      if (rd_data !== model[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, "array", 0, 0);
    else begin
      rd_addr = 8'(first);
      #0.004;
      chk(1'b0, req, $sformatf("array byte %0h (%0d bad)", first, bad), int'(rd_data), int'(model[first]));
    end
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    prog_req = 1'b1; prog_addr = a; prog_data = d; wr_en = 1'b1;
    step();
    prog_req = 1'b0;
    model[a] = model[a] & d;
  endtask

  task automatic do_erase(input logic [1:0] kind, input logic [7:0] addr, input bit we,
                          input int base, input int len, input bit exp_cap, input string req);
    int cnt = 0;
    erase_req = 1'b1; erase_kind = kind; erase_addr = addr; wr_en = we;
    step();
    erase_req = 1'b0;
    chk(cap_err == exp_cap, "R5", {req, " cap_err"}, int'(cap_err), int'(exp_cap));
    while (busy && cnt < 1000) begin
      cnt++;
      step();
    end
    chk(cnt == len, "R4", {req, " busy length"}, cnt, len);
    chk(done == (len != 0), "R4", {req, " done pulse"}, int'(done), int'(len != 0));
    step();
    chk(done == 1'b0, "R4", {req, " done one cycle"}, int'(done), 0);
    for (int i = base; i < base + len; i++) model[i] = 8'hFF;
    wr_en = 1'b1;
    sweep(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; wr_en = 1'b0; prog_req = 1'b0; erase_req = 1'b0;
    prog_addr = '0; prog_data = '0; erase_addr = '0; erase_kind = '0; rd_addr = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk({busy, done, reject, cap_err, prot_err} == 5'b0, "R1", "flags after reset",
        int'({busy, done, reject, cap_err, prot_err}), 0);
    sweep("R1");

    // R7 R8 R9 R12 program vectors on both instances
    for (int v = 0; v < 8; v++) begin
      logic [7:0] a, d, e, eo;
      logic we, pe;
      {a, d, we, e, eo, pe} = VEC[v];
      prog_req = 1'b1; prog_addr = a; prog_data = d; wr_en = we; rd_addr = a;
      step();
      prog_req = 1'b0;
      chk(prot_err == pe, "R9", $sformatf("prot_err vec %0d", v), int'(prot_err), int'(pe));
      chk(busy == 1'b0, "R12", $sformatf("no busy vec %0d", v), int'(busy), 0);
      chk(rd_data == e, "R7", $sformatf("and-merge vec %0d", v), int'(rd_data), int'(e));
      chk(rd_data_ow == eo, "R8", $sformatf("overwrite vec %0d", v), int'(rd_data_ow), int'(eo));
      model[a] = e;
    end
    wr_en = 1'b1;
    sweep("R7");

    // R2 R3 small erase at unaligned address, capability present
    do_erase(2'd0, 8'h13, 1'b1, 16'h10, 16, 1'b0, "R2 R3 small");

    // R5 medium erase with capability clear still runs
    prog(8'h45, 8'h00);
    prog(8'h60, 8'h12);
    do_erase(2'd1, 8'h47, 1'b1, 16'h40, 32, 1'b1, "R5 R3 mid");

    // R2 sector erase
    prog(8'hBF, 8'h00);
    prog(8'h7F, 8'h33);
    do_erase(2'd2, 8'hB5, 1'b1, 16'h80, 64, 1'b0, "R2 sector");

    // R6 whole-array erase with write-enable low is ignored
    do_erase(2'd3, 8'h00, 1'b0, 0, 0, 1'b0, "R6 locked chip");

    // R10 requests during a whole-array erase are rejected
    erase_req = 1'b1; erase_kind = 2'd3; erase_addr = 8'h77; wr_en = 1'b1;
    step();
    erase_req = 1'b0;
    chk(cap_err == 1'b0, "R5", "chip cap_err", int'(cap_err), 0);
    cnt = 1;
    step(); cnt++;
    step(); cnt++;
    prog_req = 1'b1; prog_addr = 8'h05; prog_data = 8'h00;
    erase_req = 1'b1; erase_kind = 2'd0; erase_addr = 8'hC0;
    step(); cnt++;
    prog_req = 1'b0; erase_req = 1'b0;
    chk(reject == 1'b1, "R10", "reject while busy", int'(reject), 1);
    step();
    while (busy && cnt < 1000) begin
      cnt++;
      step();
    end
    chk(cnt == DEPTH, "R10", "erase length unchanged", cnt, DEPTH);
    chk(done == 1'b1, "R4", "chip done", int'(done), 1);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    step();
    sweep("R10");

    // R11 program and erase together while idle: erase wins
    prog_req = 1'b1; prog_addr = 8'h20; prog_data = 8'h00;
    erase_req = 1'b1; erase_kind = 2'd0; erase_addr = 8'h08;
    step();
    prog_req = 1'b0; erase_req = 1'b0;
    chk(reject == 1'b1, "R11", "clash reject", int'(reject), 1);
    chk(busy == 1'b1, "R11", "erase started", int'(busy), 1);
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      step();
    end
    chk(cnt == 16, "R11", "clash erase length", cnt, 16);
    step();
    sweep("R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule